// File: doc/BRIEF.md
# Bit-Controlled SIMD Accumulate Unit

This unit is an arithmetic extension for bit-level signal kernels such as correlation and channel estimation. It treats a 64-bit word as eight signed 8-bit lanes and an 8-bit control register whose bits stand for values of ±1. A bit of 1 means +1 and a bit of 0 means −1. Because of this encoding, a multiply by a bit becomes a choice between add and subtract, and a product of two bits becomes an XNOR. Accumulating such a product becomes a step of +1 or −1 in each lane.

An operation is started by pulsing `issue_i` with an opcode, two 64-bit operands, the bit register and a selector. The result is computed combinationally and captured in one output register. It appears on `res_o` together with a `valid_o` strobe one clock after issue. When the unit is not issued, the output register keeps its value. Lane arithmetic can wrap or saturate, and no carry ever crosses from one lane into the next.

Top module: `bitlane_acc_unit`

## Requirements
- R1: While `rst_n` is low, `res_o` is zero and `valid_o` is low.
- R2: `valid_o` is high in exactly the cycle after a cycle in which `issue_i` was high. `res_o` changes only after an issue and holds its value otherwise.
- R3: Opcode 0 (conditional add) gives lane i = d lane i + c lane i when `breg_i[i]` is 1, and d lane i − c lane i when it is 0. Lane i occupies bits [8i+7:8i].
- R4: With `sat_i` low, lane results wrap modulo 256, and a carry or borrow out of one lane never changes another lane.
- R5: With `sat_i` high, a lane result that overflows signed 8-bit range clamps to 0x7F on the positive side and to 0x80 on the negative side.
- R6: Opcode 1 (repeat) places `breg_i` unchanged in every byte of the result.
- R7: Opcode 2 (spread) fills byte i of the result with eight copies of `breg_i[i]`.
- R8: Opcode 3 (bit product) gives the bitwise XNOR of `d_i` and `c_i`.
- R9: Opcode 4 (step), with `sel_i[7]` = 0, takes control bit i from `c_i[8r+i]`, where r = `sel_i[2:0]`. Lane i becomes d lane i + 1 when that bit is 1 and d lane i − 1 when it is 0.
- R10: Opcode 4, with `sel_i[7]` = 1, takes control bit i from `c_i[8i+k]`, where k = `sel_i[2:0]`. The bits `sel_i[6:3]` have no effect.
- R11: Opcodes 5, 6 and 7 produce an all-zero result.
- R12: The step opcode obeys `sat_i`: 0x7F + 1 stays 0x7F and 0x80 − 1 stays 0x80 when saturating, and they wrap to 0x80 and 0x7F otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Start an operation this cycle |
| op_i | input | 3 | Opcode |
| sat_i | input | 1 | 1 = saturate lanes, 0 = wrap |
| breg_i | input | 8 | ±1 control bit register |
| sel_i | input | 8 | Product bit selector for the step opcode |
| d_i | input | 64 | Accumulator operand |
| c_i | input | 64 | Second operand: integers, bit vector or product matrix |
| res_o | output | 64 | Registered result |
| valid_o | output | 1 | Result strobe, one cycle after issue |

## Verification
On every cycle, the assertions check the issue-to-strobe timing, the hold of the result between issues, the zero result of reserved opcodes, and the repeat pattern in the low byte. Inside each lane, they also check that a saturating add of two non-negative values, or a saturating subtract of a negative value from a non-negative one, never yields a negative lane. The exact lane values cannot be shown by any per-cycle property, so the bench scenarios cover them. These include mixed add/subtract masks, overflow at the lane edges with no leakage into neighbouring lanes, row and column bit selection, the ignored selector bits, and the two expansion layouts.

// File: rtl/bitlane_pkg.sv
package bitlane_pkg;
   typedef enum logic [2:0] {
      BL_CADD = 3'd0,
      BL_EXPR = 3'd1,
      BL_EXPC = 3'd2,
      BL_XNOR = 3'd3,
      BL_STEP = 3'd4
   } bl_op_e;
endpackage

// File: rtl/bitlane_lane_alu.sv
module bitlane_lane_alu #(
   parameter int W      = 8,
   parameter bit SAT_EN = 1'b1
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         sub_i,
   input  logic         sat_i,
   output logic [W-1:0] y_o
);
   localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

   if (W < 2) begin : g_bad_w
      $error("bitlane_lane_alu: W must be at least 2");
   end

   logic [W:0] ext;
   logic       ovf;

   always_comb begin
      if (sub_i) ext = {a_i[W-1], a_i} - {b_i[W-1], b_i};
      else       ext = {a_i[W-1], a_i} + {b_i[W-1], b_i};
      ovf = ext[W] ^ ext[W-1];
   end

   if (SAT_EN) begin : g_sat
      always_comb begin
         if (sat_i && ovf) y_o = ext[W] ? MINV : MAXV;
         else              y_o = ext[W-1:0];
      end

      always_comb begin
         if (sat_i && !sub_i && !a_i[W-1] && !b_i[W-1])
            AST_SAT_POS_CLAMP: assert (!y_o[W-1]); // R5
         if (sat_i && sub_i && !a_i[W-1] && b_i[W-1])
            AST_SAT_SUB_CLAMP: assert (!y_o[W-1]); // R5
      end
   end else begin : g_wrap
      logic unused_sat;
      assign unused_sat = sat_i ^ ovf;
      assign y_o = ext[W-1:0];
   end
endmodule

// File: rtl/bitlane_expand.sv
module bitlane_expand #(
   parameter int LANES  = 8,
   parameter int LANE_W = 8
) (
   input  logic [LANES-1:0]        breg_i,
   output logic [LANES*LANE_W-1:0] rep_o,
   output logic [LANES*LANE_W-1:0] spread_o
);
   if (LANES != LANE_W) begin : g_bad_shape
      $error("bitlane_expand: repeat pattern needs LANES == LANE_W");
   end

   for (genvar k = 0; k < LANES; k++) begin : g_byte
      assign rep_o[k*LANE_W +: LANE_W]    = breg_i;
      assign spread_o[k*LANE_W +: LANE_W] = {LANE_W{breg_i[k]}};
   end
endmodule

// File: rtl/bitlane_bit_pick.sv
module bitlane_bit_pick #(
   parameter int LANES  = 8,
   parameter int LANE_W = 8,
   parameter int SEL_W  = 8
) (
   input  logic [LANES*LANE_W-1:0] prod_i,
   input  logic [SEL_W-1:0]        sel_i,
   output logic [LANES-1:0]        bits_o
);
   localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

   if (SEL_W < IDX_W + 1) begin : g_bad_sel
      $error("bitlane_bit_pick: selector too narrow");
   end
   if (LANES != LANE_W) begin : g_bad_shape
      $error("bitlane_bit_pick: product must be a square bit matrix");
   end

   logic [IDX_W-1:0] idx;
   logic             col_mode;
   logic             unused_sel;

   assign idx        = sel_i[IDX_W-1:0];
   assign col_mode   = sel_i[SEL_W-1];
   assign unused_sel = ^sel_i;

   always_comb begin
      for (int k = 0; k < LANES; k++) begin
         if (col_mode) bits_o[k] = prod_i[k*LANE_W + int'(idx)];
         else          bits_o[k] = prod_i[int'(idx)*LANE_W + k];
      end
   end
endmodule

// File: rtl/bitlane_acc_unit.sv
module bitlane_acc_unit
   import bitlane_pkg::*;
#(
   parameter int LANES  = 8,
   parameter int LANE_W = 8,
   parameter int SEL_W  = 8,
   parameter bit SAT_EN = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     issue_i,
   input  logic [2:0]               op_i,
   input  logic                     sat_i,
   input  logic [LANES-1:0]         breg_i,
   input  logic [SEL_W-1:0]         sel_i,
   input  logic [LANES*LANE_W-1:0]  d_i,
   input  logic [LANES*LANE_W-1:0]  c_i,
   output logic [LANES*LANE_W-1:0]  res_o,
   output logic                     valid_o
);
   localparam int DATA_W = LANES * LANE_W;

   if (LANES < 2 || LANE_W < 2) begin : g_bad_dims
      $error("bitlane_acc_unit: need at least two lanes of two bits");
   end

   logic              is_step;
   logic [LANES-1:0]  pick;
   logic [DATA_W-1:0] lane_y;
   logic [DATA_W-1:0] rep;
   logic [DATA_W-1:0] spread;
   logic [DATA_W-1:0] nxt;

   assign is_step = (op_i == BL_STEP);

   bitlane_bit_pick #(.LANES(LANES), .LANE_W(LANE_W), .SEL_W(SEL_W)) u_pick (
      .prod_i (c_i),
      .sel_i  (sel_i),
      .bits_o (pick)
   );

   bitlane_expand #(.LANES(LANES), .LANE_W(LANE_W)) u_expand (
      .breg_i   (breg_i),
      .rep_o    (rep),
      .spread_o (spread)
   );

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [LANE_W-1:0] opnd;
      logic              do_sub;

      assign opnd   = is_step ? LANE_W'(1) : c_i[i*LANE_W +: LANE_W];
      assign do_sub = is_step ? ~pick[i] : ~breg_i[i];

      bitlane_lane_alu #(.W(LANE_W), .SAT_EN(SAT_EN)) u_alu (
         .a_i   (d_i[i*LANE_W +: LANE_W]),
         .b_i   (opnd),
         .sub_i (do_sub),
         .sat_i (sat_i),
         .y_o   (lane_y[i*LANE_W +: LANE_W])
      );
   end

   always_comb begin
      case (op_i)
         BL_CADD, BL_STEP: nxt = lane_y;
         BL_EXPR:          nxt = rep;
         BL_EXPC:          nxt = spread;
         BL_XNOR:          nxt = ~(d_i ^ c_i);
         default:          nxt = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_o   <= '0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= issue_i;
         if (issue_i) res_o <= nxt;
      end
   end

   AST_VALID_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
      issue_i |=> valid_o); // R2
   AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_i |=> !valid_o); // R2
   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_i |=> $stable(res_o)); // R2
   AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i && op_i > 3'd4) |=> (res_o == '0)); // R11
   AST_REPEAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i && op_i == BL_EXPR) |=> (res_o[LANE_W-1:0] == $past(breg_i))); // R6
endmodule

// File: tb/bitlane_acc_unit_tb_top.sv
`timescale 1ns/1ps
module bitlane_acc_unit_tb_top;
   typedef struct packed {
      logic [2:0]  op;
      logic        sat;
      logic [7:0]  breg;
      logic [7:0]  sel;
      logic [63:0] d;
      logic [63:0] c;
      logic [63:0] exp;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VECS [NV] = '{
      '{3'd0, 1'b0, 8'hFF, 8'h00, 64'h0102030405060708, 64'h0101010101010101, 64'h0203040506070809, 8'd3},  // R3 all add
      '{3'd0, 1'b0, 8'h00, 8'h00, 64'h0102030405060708, 64'h0101010101010101, 64'h0001020304050607, 8'd3},  // R3 all subtract
      '{3'd0, 1'b0, 8'h0F, 8'h00, 64'h1010101010101010, 64'h0202020202020202, 64'h0E0E0E0E12121212, 8'd3},  // R3 mixed
      '{3'd0, 1'b0, 8'hFF, 8'h00, 64'h000000000000FF7F, 64'h0000000000000101, 64'h0000000000000080, 8'd4},  // R4 wrap, no carry
      '{3'd0, 1'b1, 8'hFF, 8'h00, 64'h000000000000FF7F, 64'h0000000000000101, 64'h000000000000007F, 8'd5},  // R5 clamp high
      '{3'd0, 1'b1, 8'h00, 8'h00, 64'h0000000000000080, 64'h0000000000000101, 64'h000000000000FF80, 8'd5},  // R5 clamp low
      '{3'd1, 1'b0, 8'hA5, 8'h00, 64'h0, 64'h0, 64'hA5A5A5A5A5A5A5A5, 8'd6},                               // R6
      '{3'd2, 1'b0, 8'hA5, 8'h00, 64'h0, 64'h0, 64'hFF00FF0000FF00FF, 8'd7},                               // R7
      '{3'd3, 1'b0, 8'h00, 8'h00, 64'hF0F0F0F0F0F0F0F0, 64'hFF00FF00FF00FF00, 64'hF00FF00FF00FF00F, 8'd8},  // R8
      '{3'd4, 1'b0, 8'h00, 8'h02, 64'h1010101010101010, 64'h0000000000A50000, 64'h110F110F0F110F11, 8'd9},  // R9 row 2
      '{3'd4, 1'b0, 8'h00, 8'h83, 64'h1010101010101010, 64'h0808000000000808, 64'h11110F0F0F0F1111, 8'd10}, // R10 column 3
      '{3'd4, 1'b0, 8'h00, 8'hFB, 64'h1010101010101010, 64'h0808000000000808, 64'h11110F0F0F0F1111, 8'd10}, // R10 ignored bits
      '{3'd4, 1'b1, 8'h00, 8'h00, 64'h000000000000807F, 64'h0000000000000001, 64'hFFFFFFFFFFFF807F, 8'd12}, // R12 saturate
      '{3'd4, 1'b0, 8'h00, 8'h00, 64'h000000000000807F, 64'h0000000000000001, 64'hFFFFFFFFFFFF7F80, 8'd12}, // R12 wrap
      '{3'd5, 1'b0, 8'hFF, 8'hFF, 64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, 64'h0, 8'd11},               // R11
      '{3'd7, 1'b1, 8'hFF, 8'hFF, 64'hFFFFFFFFFFFFFFFF, 64'h1234567812345678, 64'h0, 8'd11}                // R11
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue_i = 1'b0;
   logic [2:0]  op_i = '0;
   logic        sat_i = 1'b0;
   logic [7:0]  breg_i = '0;
   logic [7:0]  sel_i = '0;
   logic [63:0] d_i = '0;
   logic [63:0] c_i = '0;
   logic [63:0] res_o;
   logic        valid_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   bitlane_acc_unit dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .issue_i (issue_i),
      .op_i    (op_i),
      .sat_i   (sat_i),
      .breg_i  (breg_i),
      .sel_i   (sel_i),
      .d_i     (d_i),
      .c_i     (c_i),
      .res_o   (res_o),
      .valid_o (valid_o)
   );

   task automatic check(input int req, input logic [63:0] got, input logic [63:0] exp,
                        input string what);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL R%0d %s: actual %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL R2 watchdog: actual hung expected finish");
         summary();
         $finish;
      end
   end

   initial begin
      logic [63:0] held;
      repeat (3) @(negedge clk);
      check(1, res_o, 64'h0, "result in reset");          // R1
      check(1, {63'h0, valid_o}, 64'h0, "valid in reset"); // R1
      rst_n = 1'b1;
      @(negedge clk);

      for (int n = 0; n < NV; n++) begin
         op_i    = VECS[n].op;
         sat_i   = VECS[n].sat;
         breg_i  = VECS[n].breg;
         sel_i   = VECS[n].sel;
         d_i     = VECS[n].d;
         c_i     = VECS[n].c;
         issue_i = 1'b1;
         @(negedge clk);
         issue_i = 1'b0;
         check(2, {63'h0, valid_o}, 64'h1, "strobe after issue"); // R2
         check(int'(VECS[n].req), res_o, VECS[n].exp, "table vector");
      end

      // R2: no issue means no strobe and a held result
      held   = res_o;
      op_i   = 3'd1;
      breg_i = 8'h3C;
      d_i    = 64'h5555555555555555;
      @(negedge clk);
      check(2, {63'h0, valid_o}, 64'h0, "no strobe without issue");
      check(2, res_o, held, "result held without issue");

      // R6 then R2: back-to-back issues each land one cycle later
      issue_i = 1'b1;
      @(negedge clk);
      check(6, res_o, 64'h3C3C3C3C3C3C3C3C, "repeat first of pair");
      op_i = 3'd3; d_i = 64'h0; c_i = 64'h0;
      @(negedge clk);
      issue_i = 1'b0;
      check(8, res_o, 64'hFFFFFFFFFFFFFFFF, "xnor of zeros second of pair");
      check(2, {63'h0, valid_o}, 64'h1, "strobe on second of pair");

      // R1: reset in mid-run clears the outputs
      rst_n = 1'b0;
      @(negedge clk);
      check(1, res_o, 64'h0, "result after mid-run reset");
      check(1, {63'h0, valid_o}, 64'h0, "valid after mid-run reset");
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule